// File: doc/BRIEF.md
# Destination address filter

This block decides, frame by frame, whether a received Ethernet frame should be kept, judging only by its 48-bit destination address. The receive path streams the six address octets into it in wire order, one octet per valid cycle, and marks the first octet with a start strobe. Idle cycles may fall between octets. One cycle after the sixth octet the block raises a one-cycle verdict strobe, along with an accept flag.

The match sources are of four kinds:
- A station slot that is always live and always compared exactly.
- Fifteen supplementary slots, each with its own enable and a per-octet don't-care mask, so that a prefix such as a multicast group range can be caught.
- Sixteen further slots that compare exactly and have an enable.
- A 64-bit multicast hash table, indexed by the top six bits of a reflected CRC-32 taken over the address.

A promiscuous control bit accepts everything. Software programs all of this through a simple word-write port. The values in use are copied from the programmed set at each frame start, so a write never takes effect part-way through a frame.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, no verdict strobe is pending, all control bits, hash words, slot enables and masks are zero, and the station slot holds 00:00:00:00:00:00. In that state a frame to the all-zero address is accepted and any other address is rejected.
- R2: A frame starts on a cycle with rx_valid and rx_sof both high. Its six octets are the cycles with rx_valid high, and any number of idle cycles may fall between them. dec_valid is high for exactly one cycle, the cycle after the sixth octet, and at no other time. dec_accept is low whenever dec_valid is low. A new rx_sof in the middle of a frame restarts the octet count. Octets with rx_valid high that arrive after a completed frame and without rx_sof produce no verdict.
- R3: The station slot (slot 0) is compared exactly on all six octets and is always live. Its enable bit, its mask field and the supplementary-enable control bit have no effect on it.
- R4: Register map, written with cfg_we high. Address 0x00 is control: bit 0 promiscuous, bit 1 supplementary-slot enable, bit 2 hash enable. Address 0x02 holds hash bits 31:0 and 0x03 holds hash bits 63:32. Slot i (0 to 31) has its upper word at 0x40+2i, laid out as: bit 31 enable, bits 29:24 don't-care mask (bit 24+k covers octet k, octet 0 first on the wire), bits 15:8 octet 0, bits 7:0 octet 1. Its lower word at 0x41+2i holds octets 2 to 5 in bits 31:24 down to 7:0.
- R5: Slots 1 to 15 match when the control supplementary bit and the slot enable are both set, and every octet either equals the programmed octet or has its don't-care bit set.
- R6: Slots 16 to 31 match only when the control supplementary bit and the slot enable are both set and all six octets are equal. Their don't-care mask has no effect.
- R7: The hash uses a CRC-32 with the reflected polynomial 0xEDB88320, an initial value of all ones and no final inversion. It runs over the six octets in wire order, least significant bit of each octet first. CRC bits 31:26 index the 64-bit table: bit 31 selects the upper or lower word and bits 30:26 select the bit within it. A set table bit accepts the frame only while the hash-enable bit is set.
- R8: With the promiscuous bit set, every frame is accepted.
- R9: A frame that meets none of R3, R5, R6, R7 and R8 is rejected.
- R10: Configuration writes made on or after the start cycle of a frame do not affect that frame's verdict. They apply from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | An address octet is present on rx_byte |
| rx_sof | input | 1 | First octet of a new frame (qualified by rx_valid) |
| rx_byte | input | 8 | Address octet, wire order |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Frame accepted (meaningful with dec_valid) |

## Verification
Most internal faults in this filter show up in the very next verdict, which arrives one cycle after the sixth octet. If the octet counter is off, the strobe shifts by a cycle or disappears. If the CRC register keeps a stale seed, the hash verdict flips for addresses whose index bits then differ. A bank copy taken at the wrong moment is different: it shows one frame late, as a verdict that follows the old or the new settings when it should follow the other. The bench therefore places writes on the start cycle and in the middle of a frame, and then looks at two consecutive verdicts.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int          ADDR_OCTETS = 6;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;

    // configuration word addresses below the slot window
    localparam int A_CTRL    = 0;
    localparam int A_HASH_LO = 2;
    localparam int A_HASH_HI = 3;

    typedef logic [8*ADDR_OCTETS-1:0] mac_t;

    typedef struct packed {
        logic                   en;
        logic [ADDR_OCTETS-1:0] dontcare;
        mac_t                   mac;
    } slot_t;

    typedef struct packed {
        logic hash_en;
        logic supp_en;
        logic promisc;
    } ctrl_t;

    // one octet step of the reflected CRC-32
    function automatic logic [31:0] crc_octet(input logic [31:0] seed, input logic [7:0] octet);
        logic [31:0] r;
        r = seed ^ {24'd0, octet};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/daf_cfg.sv
module daf_cfg
    import daf_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int AW    = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [31:0]            wdata,
    input  logic                   load,
    output ctrl_t                  act_ctrl,
    output logic [63:0]            act_hash,
    output slot_t [NSLOT-1:0]      act_slot
);

    localparam int SIW = $clog2(NSLOT);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [63:0]       hash;
        slot_t [NSLOT-1:0] slot;
    } bank_t;

    typedef struct packed {
        bank_t stage;
        bank_t act;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (waddr == AW'(A_CTRL)) begin
                cfg_d.stage.ctrl = wdata[2:0];
            end else if (waddr == AW'(A_HASH_LO)) begin
                cfg_d.stage.hash[31:0] = wdata;
            end else if (waddr == AW'(A_HASH_HI)) begin
                cfg_d.stage.hash[63:32] = wdata;
            end else if (waddr[AW-1]) begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (waddr[SIW:1] == SIW'(i)) begin
                        if (!waddr[0]) begin
                            cfg_d.stage.slot[i].en        = wdata[31];
                            cfg_d.stage.slot[i].dontcare  = wdata[24 +: ADDR_OCTETS];
                            cfg_d.stage.slot[i].mac[47:32] = wdata[15:0];
                        end else begin
                            cfg_d.stage.slot[i].mac[31:0] = wdata;
                        end
                    end
                end
            end
        end
        // the in-use bank takes the programmed set as it stood before this cycle
        if (load) begin
            cfg_d.act = cfg_q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_ctrl = cfg_q.act.ctrl;
    assign act_hash = cfg_q.act.hash;
    assign act_slot = cfg_q.act.slot;

endmodule

// File: rtl/daf_crc.sv
module daf_crc
    import daf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        step,
    input  logic [7:0]  octet,
    output logic [31:0] crc_nxt
);

    logic [31:0] crc_d, crc_q;
    logic [31:0] seed;

    always_comb begin
        seed    = start ? 32'hFFFF_FFFF : crc_q;
        crc_nxt = crc_octet(seed, octet);
        crc_d   = step ? crc_nxt : crc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else begin
            crc_q <= crc_d;
        end
    end

endmodule

// File: rtl/daf_match.sv
module daf_match
    import daf_pkg::*;
#(
    parameter int NSLOT   = 32,
    parameter int NMASKED = 16
) (
    input  mac_t              addr,
    input  logic              supp_en,
    input  slot_t [NSLOT-1:0] slot,
    output logic [NSLOT-1:0]  hit
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i == 0) begin : g_station
            assign hit[i] = (addr == slot[i].mac);
        end else if (i < NMASKED) begin : g_masked
            logic [ADDR_OCTETS-1:0] octet_ok;
            for (genvar k = 0; k < ADDR_OCTETS; k++) begin : g_octet
                localparam int HI = 8*ADDR_OCTETS - 1 - 8*k;
                assign octet_ok[k] = slot[i].dontcare[k] ||
                                     (addr[HI -: 8] == slot[i].mac[HI -: 8]);
            end
            assign hit[i] = supp_en && slot[i].en && (&octet_ok);
        end else begin : g_exact
            assign hit[i] = supp_en && slot[i].en && (addr == slot[i].mac);
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int NSLOT   = 32,
    parameter int NMASKED = 16,
    parameter int CFG_AW  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam int CW     = $clog2(ADDR_OCTETS + 1);
    localparam int HEAD_W = 8 * (ADDR_OCTETS - 1);

    typedef struct packed {
        logic              busy;
        logic [CW-1:0]     cnt;
        logic [HEAD_W-1:0] head;
        logic              dec_valid;
        logic              dec_accept;
    } seq_t;

    seq_t seq_d, seq_q;

    ctrl_t             act_ctrl;
    logic [63:0]       act_hash;
    slot_t [NSLOT-1:0] act_slot;
    logic [NSLOT-1:0]  hit;
    logic [31:0]       crc_nxt;
    logic              take;
    logic              last;
    logic [CW-1:0]     pos;
    mac_t              full_addr;
    logic              hash_hit;
    logic              verdict;

    assign take      = rx_valid && (rx_sof || seq_q.busy);
    assign pos       = rx_sof ? '0 : seq_q.cnt;
    assign last      = take && (pos == CW'(ADDR_OCTETS - 1));
    assign full_addr = {seq_q.head, rx_byte};

    daf_cfg #(
        .NSLOT (NSLOT),
        .AW    (CFG_AW)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .load     (rx_valid && rx_sof),
        .act_ctrl (act_ctrl),
        .act_hash (act_hash),
        .act_slot (act_slot)
    );

    daf_crc i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rx_sof),
        .step    (take),
        .octet   (rx_byte),
        .crc_nxt (crc_nxt)
    );

    daf_match #(
        .NSLOT   (NSLOT),
        .NMASKED (NMASKED)
    ) i_match (
        .addr    (full_addr),
        .supp_en (act_ctrl.supp_en),
        .slot    (act_slot),
        .hit     (hit)
    );

    assign hash_hit = act_ctrl.hash_en && act_hash[crc_nxt[31:26]];
    assign verdict  = act_ctrl.promisc || (|hit) || hash_hit;

    always_comb begin
        seq_d            = seq_q;
        seq_d.dec_valid  = 1'b0;
        seq_d.dec_accept = 1'b0;
        if (take) begin
            seq_d.head = {seq_q.head[HEAD_W-9:0], rx_byte};
            seq_d.cnt  = pos + CW'(1);
            seq_d.busy = !last;
        end
        if (last) begin
            seq_d.dec_valid  = 1'b1;
            seq_d.dec_accept = verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dec_valid  = seq_q.dec_valid;
    assign dec_accept = seq_q.dec_accept;

endmodule

// File: rtl/daf_checker.sv
module daf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        rx_sof,
    input logic [7:0]  rx_byte,
    input logic        dec_valid,
    input logic        dec_accept,
    input logic [2:0]  ctrl_bits,
    input logic [47:0] station
);

    logic [2:0]  c_cnt;
    logic        c_on;
    logic [39:0] c_head;
    logic        c_take;
    logic [2:0]  c_pos;
    logic        sixth;

    assign c_take = rx_valid && (rx_sof || c_on);
    assign c_pos  = rx_sof ? 3'd0 : c_cnt;
    assign sixth  = c_take && (c_pos == 3'd5);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cnt  <= '0;
            c_on   <= 1'b0;
            c_head <= '0;
        end else if (c_take) begin
            c_cnt  <= c_pos + 3'd1;
            c_on   <= !sixth;
            c_head <= {c_head[31:0], rx_byte};
        end
    end

    p_valid_after_sixth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sixth |=> dec_valid);

    p_valid_only_after_sixth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(sixth));

    p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept);

    p_promisc_accepts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sixth && ctrl_bits[0]) |=> dec_accept);

    p_station_accepts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sixth && ({c_head, rx_byte} == station)) |=> dec_accept);

    p_bank_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_sof) |=> ($stable(ctrl_bits) && $stable(station)));

endmodule

bind dst_addr_filter daf_checker i_daf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_sof     (rx_sof),
    .rx_byte    (rx_byte),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .ctrl_bits  (act_ctrl),
    .station    (act_slot[0].mac)
);

// File: tb/test_dst_addr_filter.sv
`timescale 1ns/1ps
module test_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = 7'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic        dec_valid;
    logic        dec_accept;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_byte    (rx_byte),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    typedef struct packed {
        logic [47:0] mac;
        logic        acc;
    } vec_t;

    // supplementary-enable on; slots programmed as in the setup below
    localparam vec_t VEC [0:10] = '{
        {48'h02_00_00_00_00_01, 1'b1},   // R3 station
        {48'h02_00_00_00_00_02, 1'b0},   // R9
        {48'h01_00_5E_12_34_56, 1'b1},   // R5 prefix of three
        {48'h01_00_5F_12_34_56, 1'b0},   // R5 prefix miss
        {48'h33_33_FF_00_00_01, 1'b1},   // R5 prefix of two
        {48'h33_34_FF_00_00_01, 1'b0},   // R5 miss
        {48'h0A_0B_0C_0D_0E_0F, 1'b1},   // R5 no mask
        {48'h0A_0B_0C_0D_0E_0E, 1'b0},   // R5 last octet differs
        {48'h0A_00_00_00_00_11, 1'b1},   // R6 exact
        {48'h0A_00_00_00_FF_11, 1'b0},   // R6 mask ignored
        {48'h0A_00_00_00_00_22, 1'b0}    // R6 disabled slot
    };

    function automatic logic [31:0] crc_model(input logic [47:0] mac);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[0] ^ mac[47 - 8*k - 7 + b];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic slot_write(input int i, input logic en, input logic [5:0] dc, input logic [47:0] mac);
        cfg_write(7'(64 + 2*i), {en, 1'b0, dc, 8'h00, mac[47:32]});
        cfg_write(7'(65 + 2*i), mac[31:0]);
    endtask

    task automatic send_frame(input logic [47:0] mac, input int gap, input int wr_at,
                              input logic [6:0] wa, input logic [31:0] wd,
                              output logic early, output logic got_v,
                              output logic got_a, output logic after);
        early = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (dec_valid) early = 1'b1;
            rx_valid  = 1'b1;
            rx_sof    = (k == 0);
            rx_byte   = mac[47 - 8*k -: 8];
            cfg_we    = (k == wr_at);
            cfg_addr  = wa;
            cfg_wdata = wd;
            if (k < 5) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    if (dec_valid) early = 1'b1;
                    rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0; rx_byte = 8'hA5;
                end
            end
        end
        @(negedge clk);
        got_v = dec_valid;
        got_a = dec_accept;
        rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        after = dec_valid;
    endtask

    task automatic frame(input logic [47:0] mac, input logic exp_acc, input string req);
        logic e, v, a, f;
        send_frame(mac, 0, -1, 7'h0, 32'h0, e, v, a, f);
        chk(req, {28'd0, e, v, f, a}, {28'd0, 1'b0, 1'b1, 1'b0, exp_acc});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic        e, v, a, f, seen;
        logic [31:0] c;
        logic [5:0]  ix;
        logic [47:0] m2;
        localparam logic [47:0] HMAC = 48'h01_00_5E_00_00_FB;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 verdict idle", {30'd0, dec_valid, dec_accept}, 32'd0);
        frame(48'h00_00_00_00_00_00, 1'b1, "R1 zero station");
        frame(48'h02_11_22_33_44_55, 1'b0, "R1 other address");

        // R4 programming
        slot_write(0, 1'b0, 6'h00, 48'h02_00_00_00_00_01);
        slot_write(1, 1'b1, 6'h38, 48'h01_00_5E_00_00_00);
        slot_write(2, 1'b1, 6'h3C, 48'h33_33_00_00_00_00);
        slot_write(3, 1'b1, 6'h00, 48'h0A_0B_0C_0D_0E_0F);
        slot_write(17, 1'b1, 6'h3F, 48'h0A_00_00_00_00_11);
        slot_write(18, 1'b0, 6'h00, 48'h0A_00_00_00_00_22);
        cfg_write(7'h00, 32'h2);

        for (int i = 0; i <= 10; i++) begin
            frame(VEC[i].mac, VEC[i].acc, "R5/R6 vector table");
        end

        // supplementary bit off
        cfg_write(7'h00, 32'h0);
        frame(48'h01_00_5E_12_34_56, 1'b0, "R5 supp bit off");
        frame(48'h0A_00_00_00_00_11, 1'b0, "R6 supp bit off");
        frame(48'h02_00_00_00_00_01, 1'b1, "R3 independent of supp");

        // station enable and mask fields have no effect
        slot_write(0, 1'b0, 6'h3F, 48'h02_00_00_00_00_01);
        frame(48'h02_00_00_00_00_01, 1'b1, "R3 enable ignored");
        frame(48'h02_00_00_00_00_07, 1'b0, "R3 mask ignored");

        // R7 hash table
        c  = crc_model(HMAC);
        ix = c[31:26];
        cfg_write(ix[5] ? 7'h03 : 7'h02, 32'd1 << ix[4:0]);
        cfg_write(ix[5] ? 7'h02 : 7'h03, 32'd0);
        cfg_write(7'h00, 32'h4);
        frame(HMAC, 1'b1, "R7 indexed bit set");
        m2 = HMAC;
        for (int t = 0; t < 256; t++) begin
            m2[7:0] = 8'(t);
            c = crc_model(m2);
            if (c[31:26] != ix) break;
        end
        frame(m2, 1'b0, "R7 other index");
        cfg_write(ix[5] ? 7'h03 : 7'h02, 32'd0);
        cfg_write(ix[5] ? 7'h02 : 7'h03, 32'd1 << ix[4:0]);
        frame(HMAC, 1'b0, "R7 wrong word");
        cfg_write(ix[5] ? 7'h03 : 7'h02, 32'd1 << ix[4:0]);
        cfg_write(7'h00, 32'h0);
        frame(HMAC, 1'b0, "R7 hash disabled");

        // R8 / R9
        cfg_write(7'h00, 32'h1);
        frame(48'h12_34_56_78_9A_BC, 1'b1, "R8 promiscuous");
        cfg_write(7'h00, 32'h0);
        frame(48'h12_34_56_78_9A_BC, 1'b0, "R9 nothing matches");

        // R2 gaps between octets
        send_frame(48'h02_00_00_00_00_01, 2, -1, 7'h0, 32'h0, e, v, a, f);
        chk("R2 gapped frame", {28'd0, e, v, f, a}, {28'd0, 4'b0101});

        // R2 restart on a second start strobe
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'hFF;
        @(negedge clk);
        rx_sof = 1'b0; rx_byte = 8'hEE;
        @(negedge clk);
        rx_byte = 8'hDD;
        frame(48'h02_00_00_00_00_01, 1'b1, "R2 restart");

        // R2 octets with no start strobe
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (dec_valid) seen = 1'b1;
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'h02;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (dec_valid) seen = 1'b1;
            rx_valid = 1'b0;
        end
        chk("R2 octets without start", {31'd0, seen}, 32'd0);

        // R10 write in mid-frame and on the start cycle
        send_frame(48'h12_34_56_78_9A_BC, 0, 2, 7'h00, 32'h1, e, v, a, f);
        chk("R10 mid-frame write deferred", {28'd0, e, v, f, a}, {28'd0, 4'b0100});
        frame(48'h12_34_56_78_9A_BC, 1'b1, "R10 write applied next frame");
        send_frame(48'h12_34_56_78_9A_BC, 0, 0, 7'h00, 32'h0, e, v, a, f);
        chk("R10 start-cycle write deferred", {28'd0, e, v, f, a}, {28'd0, 4'b0101});
        frame(48'h12_34_56_78_9A_BC, 1'b0, "R10 cleared next frame");

        // R1 reset clears programmed state
        cfg_write(7'h00, 32'h1);
        frame(48'h12_34_56_78_9A_BC, 1'b1, "R8 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 verdict idle after reset", {30'd0, dec_valid, dec_accept}, 32'd0);
        frame(48'h12_34_56_78_9A_BC, 1'b0, "R1 control cleared");
        frame(48'h02_00_00_00_00_01, 1'b0, "R1 station cleared");
        frame(48'h00_00_00_00_00_00, 1'b1, "R1 station zero");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule